// File: doc/BRIEF.md
# Crate-Bus Offset and Control Register File

This block is the register file of a 16-channel charge digitizer as seen from a crate dataway bus. A bus command is a function code, a subaddress, a 15-bit write word and a strobe. The block holds one 8-bit offset (pedestal) word per channel and a 15-bit control word. The low byte of the control word is the module's station number and the upper seven bits are command flags. A ready/busy input from the conversion logic gates every bus access. A refused or unknown command leaves all state alone and returns no acknowledge.

There is a second, independent port for the fast readout path. It takes a channel index and a raw conversion result each clock. One clock later it returns either the raw value or the raw value minus that channel's stored offset, floored at zero. Control bit 8 selects which. The bus initialize input clears only the command flags. No reset or initialize touches the offset memory.

Top module: `crate_regfile`

## Requirements
- R1: When `cmd_strobe` is high, `ready` is high, `bus_init` is low and `cmd_func` is 17, `cmd_wdata[7:0]` is written to the offset word of channel `cmd_sub` (0..15), and `q_ack` is high in the following cycle.
- R2: An accepted function 1 with subaddress n makes `q_ack` high in the following cycle. In that same cycle `cmd_rdata[7:0]` holds channel n's offset and `cmd_rdata[14:8]` is zero.
- R3: An accepted function 16 with subaddress 0 loads all 15 bits of `cmd_wdata` into the control word. An accepted function 0 with subaddress 0 returns the control word on `cmd_rdata[14:0]` in the following cycle, with `q_ack` high.
- R4: While `ready` is low, no command is acknowledged. The offset memory and the control word stay unchanged, and `cmd_rdata` stays zero.
- R5: Any other command produces no `q_ack`, no state change and zero `cmd_rdata` in the following cycle. This covers a strobe-low cycle, a function code other than 0, 1, 16 or 17, and function 0 or 16 with a nonzero subaddress.
- R6: A cycle with `bus_init` high clears control bits 14..8 and keeps bits 7..0 (station number). No command is accepted in that cycle, and the offset memory is unchanged.
- R7: Synchronous `rst` clears the control word, `q_ack`, `cmd_rdata` and `fp_out`, and leaves the offset memory unchanged.
- R8: `fp_out` in cycle k+1 is derived from `fp_raw`, `fp_chan` and control bit 8 as they were in cycle k. With bit 8 low it equals `fp_raw`. With bit 8 high it equals `fp_raw` minus the offset of channel `fp_chan`.
- R9: With subtraction on and an offset larger than `fp_raw`, `fp_out` is 0. It never wraps, so `fp_out` is never larger than the previous cycle's `fp_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Bus initialize: clears command flags |
| cmd_strobe | input | 1 | Command strobe, one cycle per command |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress / channel |
| cmd_wdata | input | 15 | Write word (bit 0 = first write line) |
| ready | input | 1 | High when the conversion logic is idle |
| q_ack | output | 1 | Command accepted, one cycle after the strobe |
| cmd_rdata | output | 15 | Read word for functions 0 and 1, else zero |
| fp_chan | input | 4 | Fast-port channel index |
| fp_raw | input | 12 | Fast-port raw conversion result |
| fp_out | output | 12 | Corrected or raw result, one cycle later |

## Verification
The assertions check several properties on every cycle. A busy or strobe-free cycle yields no acknowledge, and a busy cycle holds the control word. Initialize clears the flags while holding the station byte. Reset clears the outputs. With subtraction off the fast path passes raw values through, and the fast path never returns more than its input. The bench scenarios cover what needs history or stored data: the exact offset and control values read back, subtraction against each stored offset, and floor-at-zero results. They also show that refused, malformed and initialize-time commands leave the memory intact, and that offsets survive both initialize and reset.

// File: rtl/crate_regfile_pkg.sv
package crate_regfile_pkg;
  localparam int FUNC_W = 5;
  localparam logic [FUNC_W-1:0] FN_RD_STAT = 5'd0;
  localparam logic [FUNC_W-1:0] FN_RD_OFS  = 5'd1;
  localparam logic [FUNC_W-1:0] FN_WR_STAT = 5'd16;
  localparam logic [FUNC_W-1:0] FN_WR_OFS  = 5'd17;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR_OFS,
    OP_RD_OFS,
    OP_WR_STAT,
    OP_RD_STAT
  } op_e;
endpackage

// File: rtl/crate_cmd_decode.sv
module crate_cmd_decode
  import crate_regfile_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              strobe,
  input  logic              ready,
  input  logic              init,
  input  logic [FUNC_W-1:0] func,
  input  logic [CHAN_W-1:0] sub,
  output op_e               op
);
  always_comb begin
    op = OP_NONE;
    if (strobe && ready && !init) begin
      case (func)
        FN_WR_OFS:  op = OP_WR_OFS;
        FN_RD_OFS:  op = OP_RD_OFS;
        FN_WR_STAT: if (sub == '0) op = OP_WR_STAT;
        FN_RD_STAT: if (sub == '0) op = OP_RD_STAT;
        default:    op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/crate_offset_mem.sv
module crate_offset_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic [AW-1:0] fp_raddr,
  output logic [DW-1:0] fp_rdata
);
  // No reset on purpose: contents survive every clear.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    bus_rdata <= mem[bus_raddr];
  end

  assign fp_rdata = mem[fp_raddr];
endmodule

// File: rtl/crate_status_reg.sv
module crate_status_reg #(
  parameter int W    = 15,
  parameter int ID_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else if (init) begin
      stat[W-1:ID_W] <= '0;
    end else if (we) begin
      stat <= wdata;
    end
  end
endmodule

// File: rtl/crate_offset_sub.sv
module crate_offset_sub #(
  parameter int RAW_W = 12,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [RAW_W-1:0] raw,
  input  logic [DW-1:0]    ofs,
  output logic [RAW_W-1:0] res
);
  logic [RAW_W-1:0] ofs_ext;
  assign ofs_ext = {{(RAW_W-DW){1'b0}}, ofs};

  always_ff @(posedge clk) begin
    if (rst)                 res <= '0;
    else if (!en)            res <= raw;
    else if (raw < ofs_ext)  res <= '0;
    else                     res <= raw - ofs_ext;
  end
endmodule

// File: rtl/crate_regfile.sv
module crate_regfile
  import crate_regfile_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int OFS_W    = 8,
  parameter int STAT_W   = 15,
  parameter int ID_W     = 8,
  parameter int RAW_W    = 12,
  localparam int CHAN_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_init,
  input  logic              cmd_strobe,
  input  logic [FUNC_W-1:0] cmd_func,
  input  logic [CHAN_W-1:0] cmd_sub,
  input  logic [STAT_W-1:0] cmd_wdata,
  input  logic              ready,
  output logic              q_ack,
  output logic [STAT_W-1:0] cmd_rdata,
  input  logic [CHAN_W-1:0] fp_chan,
  input  logic [RAW_W-1:0]  fp_raw,
  output logic [RAW_W-1:0]  fp_out
);
  localparam int SUB_EN_BIT = ID_W;

  op_e               op, op_q;
  logic [OFS_W-1:0]  ofs_bus, ofs_fp;
  logic [STAT_W-1:0] status_q;

  crate_cmd_decode #(.CHAN_W(CHAN_W)) u_dec (
    .strobe(cmd_strobe), .ready(ready), .init(bus_init),
    .func(cmd_func), .sub(cmd_sub), .op(op)
  );

  crate_offset_mem #(.DEPTH(CHANNELS), .DW(OFS_W)) u_mem (
    .clk(clk), .we(op == OP_WR_OFS), .waddr(cmd_sub),
    .wdata(cmd_wdata[OFS_W-1:0]),
    .bus_raddr(cmd_sub), .bus_rdata(ofs_bus),
    .fp_raddr(fp_chan), .fp_rdata(ofs_fp)
  );

  crate_status_reg #(.W(STAT_W), .ID_W(ID_W)) u_stat (
    .clk(clk), .rst(rst), .init(bus_init),
    .we(op == OP_WR_STAT), .wdata(cmd_wdata), .stat(status_q)
  );

  crate_offset_sub #(.RAW_W(RAW_W), .DW(OFS_W)) u_sub (
    .clk(clk), .rst(rst), .en(status_q[SUB_EN_BIT]),
    .raw(fp_raw), .ofs(ofs_fp), .res(fp_out)
  );

  // Registered acknowledge and read-word snapshot.
  logic [STAT_W-1:0] stat_snap;
  always_ff @(posedge clk) begin
    if (rst) begin
      q_ack     <= 1'b0;
      op_q      <= OP_NONE;
      stat_snap <= '0;
    end else begin
      q_ack     <= (op != OP_NONE);
      op_q      <= op;
      stat_snap <= status_q;
    end
  end

  always_comb begin
    case (op_q)
      OP_RD_OFS:  cmd_rdata = {{(STAT_W-OFS_W){1'b0}}, ofs_bus};
      OP_RD_STAT: cmd_rdata = stat_snap;
      default:    cmd_rdata = '0;
    endcase
  end
endmodule

// File: rtl/crate_regfile_chk.sv
module crate_regfile_chk #(
  parameter int STAT_W = 15,
  parameter int ID_W   = 8,
  parameter int RAW_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_init,
  input logic              cmd_strobe,
  input logic              ready,
  input logic              q_ack,
  input logic [STAT_W-1:0] cmd_rdata,
  input logic [STAT_W-1:0] status_q,
  input logic [RAW_W-1:0]  fp_raw,
  input logic [RAW_W-1:0]  fp_out
);
  assert_busy_no_q_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && cmd_strobe && !ready) |=> !q_ack);

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ready && !bus_init) |=> $stable(status_q));

  assert_no_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cmd_strobe) |=> (!q_ack && cmd_rdata == '0));

  assert_init_keeps_id_R6: assert property (@(posedge clk) disable iff (rst)
    (!rst && bus_init) |=> (status_q[STAT_W-1:ID_W] == '0 &&
                            status_q[ID_W-1:0] == $past(status_q[ID_W-1:0])));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!q_ack && cmd_rdata == '0 && fp_out == '0));

  assert_raw_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (!rst && !status_q[ID_W]) |=> (fp_out == $past(fp_raw)));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (fp_out <= $past(fp_raw)));
endmodule

bind crate_regfile crate_regfile_chk #(
  .STAT_W(STAT_W), .ID_W(ID_W), .RAW_W(RAW_W)
) i_chk (
  .clk(clk), .rst(rst), .bus_init(bus_init), .cmd_strobe(cmd_strobe),
  .ready(ready), .q_ack(q_ack), .cmd_rdata(cmd_rdata),
  .status_q(status_q), .fp_raw(fp_raw), .fp_out(fp_out)
);

// File: tb/test_crate_regfile.sv
module test_crate_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_init = 1'b0;
  logic        cmd_strobe = 1'b0;
  logic [4:0]  cmd_func = '0;
  logic [3:0]  cmd_sub = '0;
  logic [14:0] cmd_wdata = '0;
  logic        ready = 1'b1;
  logic        q_ack;
  logic [14:0] cmd_rdata;
  logic [3:0]  fp_chan = '0;
  logic [11:0] fp_raw = '0;
  logic [11:0] fp_out;

  always #5 clk = ~clk;

  crate_regfile i_crate_regfile (
    .clk(clk), .rst(rst), .bus_init(bus_init), .cmd_strobe(cmd_strobe),
    .cmd_func(cmd_func), .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
    .ready(ready), .q_ack(q_ack), .cmd_rdata(cmd_rdata),
    .fp_chan(fp_chan), .fp_raw(fp_raw), .fp_out(fp_out)
  );

  // Reference model state
  int    ofs_m [16];
  bit    ofs_ok [16];
  int    stat_m = 0;
  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R7";

  int e_q, e_rd, e_fp;
  bit rd_known, fp_known;
  string fp_req;

  task automatic check(string req, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h (cycle %0d)", req, what, got, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    e_q = 0; e_rd = 0; rd_known = 1; fp_known = 1; fp_req = "R8";
    if (rst) begin
      stat_m = 0; e_fp = 0; fp_req = "R7";
    end else begin
      if (stat_m[8] == 0) e_fp = int'(fp_raw);
      else begin
        fp_known = ofs_ok[fp_chan];
        if (int'(fp_raw) < ofs_m[fp_chan]) begin e_fp = 0; fp_req = "R9"; end
        else e_fp = int'(fp_raw) - ofs_m[fp_chan];
      end
      if (bus_init) stat_m = stat_m & 8'hFF;
      else if (cmd_strobe && ready) begin
        case (cmd_func)
          5'd17: begin ofs_m[cmd_sub] = int'(cmd_wdata[7:0]); ofs_ok[cmd_sub] = 1; e_q = 1; end
          5'd1:  begin e_rd = ofs_m[cmd_sub]; rd_known = ofs_ok[cmd_sub]; e_q = 1; end
          5'd16: if (cmd_sub == 0) begin stat_m = int'(cmd_wdata); e_q = 1; end
          5'd0:  if (cmd_sub == 0) begin e_rd = stat_m; e_q = 1; end
          default: ;
        endcase
      end
    end
    @(negedge clk);
    cyc++;
    check(cur_req, "q_ack", int'(q_ack), e_q);
    if (rd_known) check(cur_req, "cmd_rdata", int'(cmd_rdata), e_rd);
    if (fp_known) check(fp_req, "fp_out", int'(fp_out), e_fp);
    // next fast-port pattern
    fp_chan = 4'(cyc * 5);
    if (cyc % 3 == 0) fp_raw = 12'(cyc % 300);
    else              fp_raw = 12'((cyc * 97 + 13) % 4096);
    cmd_strobe = 1'b0;
    bus_init = 1'b0;
  endtask

  task automatic cmd(input int f, input int s, input int w, input bit stb = 1'b1);
    cmd_func = 5'(f); cmd_sub = 4'(s); cmd_wdata = 15'(w); cmd_strobe = stb;
    step();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ofs_ok[i] = 0;
    // R7: reset state
    cur_req = "R7";
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1: load every channel offset, including 0 and 255
    cur_req = "R1";
    for (int ch = 0; ch < 16; ch++)
      cmd(17, ch, (ch == 3) ? 0 : (ch == 15) ? 255 : ((ch * 37 + 11) & 255) | 15'h7F00);

    // R2: read them back
    cur_req = "R2";
    for (int ch = 0; ch < 16; ch++) cmd(1, ch, 0);

    // R3 + R8: station byte only, subtraction off
    cur_req = "R3";
    cmd(16, 0, 15'h005A);
    cmd(0, 0, 0);
    cur_req = "R8";
    repeat (10) step();

    // R3: subtraction on with upper flags set
    cur_req = "R3";
    cmd(16, 0, 15'h7FA5);
    cmd(0, 0, 0);
    // R8/R9: fast path subtracting and saturating
    cur_req = "R8";
    repeat (48) step();

    // R4: busy refuses everything
    cur_req = "R4";
    ready = 1'b0;
    cmd(17, 2, 15'h0011);
    cmd(16, 0, 15'h0000);
    cmd(1, 2, 0);
    cmd(0, 0, 0);
    ready = 1'b1;
    cmd(1, 2, 0);
    cmd(0, 0, 0);

    // R5: malformed and unknown commands
    cur_req = "R5";
    cmd(16, 3, 15'h0001);
    cmd(0, 5, 0);
    cmd(5, 0, 15'h0022);
    cmd(17, 4, 15'h0033, 1'b0);
    cmd(1, 4, 0);
    cmd(0, 0, 0);

    // R6: initialize clears flags, keeps station byte and memory
    cur_req = "R6";
    bus_init = 1'b1;
    cmd(17, 6, 15'h00EE);
    cmd(0, 0, 0);
    cmd(1, 6, 0);
    cmd(1, 15, 0);
    repeat (6) step();

    // R7: reset again, offsets survive
    cur_req = "R7";
    rst = 1'b1;
    step();
    rst = 1'b0;
    cmd(0, 0, 0);
    cmd(1, 7, 0);
    cmd(16, 0, 15'h0100);
    cur_req = "R9";
    repeat (30) step();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule